// File: doc/BRIEF.md
# Match-Compare Timer with Watchdog

This block keeps a free-running up-counter that advances by one on every clock where the tick-enable input is high. Four compare registers sit beside it. When an update moves the counter onto a compare value, that channel's event is recorded in a status register, but only if the channel's interrupt-enable bit is set. Each status bit drives an interrupt line directly, and software clears it by writing a one to it. Channel 3 can also act as a one-shot watchdog. When it matches while armed, the block pulses a reset request and disarms itself.

Software reaches the block through a small register bus that uses byte offsets on word boundaries. A request is taken when `req_valid` is high and `req_ready` is high. `req_ready` is always high, so the block never stalls a request. A read returns one cycle after it is accepted, on `rsp_valid`. The response channel has no ready: the requester must take the response in the cycle it appears. Writes produce no response.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the counter, all four compare values, the status bits, the enable bits and the watchdog arm bit are 0. `irq`, `wdog_rst_req`, `rsp_valid` and `rsp_err` are low.
- R2: Register offsets are as follows. Compare channel i is at 4*i (0x00 to 0x0C). The counter is at 0x10. Status is at 0x14, in bits 3:0. The watchdog arm bit is bit 0 of 0x18. Interrupt enable is at 0x1C, and only bits 11:0 are stored (upper bits read 0); bit i enables channel i. A read accepted in cycle N returns `rsp_valid`=1 in cycle N+1, with the register value as it stood before the edge that ends cycle N.
- R3: A counter update is either a tick or a counter write. When the value after an update equals compare i and enable bit i is 1, status bit i sets at that same edge, and `irq[i]` follows status bit i. When enable bit i is 0, no event is recorded.
- R4: A write to 0x14 clears every status bit written as 1 and leaves the bits written as 0 unchanged. A new event in the same cycle as the clear leaves its bit set.
- R5: When an update lands on compare 3 while the arm bit is 1, `wdog_rst_req` is high for exactly one cycle after that edge and the arm bit becomes 0. This happens whatever enable bit 3 is set to. The disarm wins over a write to 0x18 in the same cycle.
- R6: Each tick adds one modulo 2^32. From 0xFFFFFFFF the counter goes to 0, and a compare value of 0 matches on that step.
- R7: With no tick and no counter write, the counter holds. A counter sitting on a compare value produces no further event, so each transition onto a value gives exactly one event.
- R8: A counter write loads the written value and takes priority over a tick in the same cycle. A load onto a compare value counts as a transition and records an event.
- R9: A read at an offset that is not mapped or not word aligned returns `rsp_err`=1 with `rsp_rdata`=0. A write to such an offset changes no register.
- R10: `req_ready` is constantly 1. `rsp_rdata` and `rsp_err` are 0 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advances on cycles where this is high |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Read hit an unmapped or unaligned offset |
| irq | output | 4 | Per-channel interrupt, equal to the status bits |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with its defaults: a 32-bit data path and counter, four channels, 12 enable bits and an 8-bit offset. Because the counter can be preloaded, wraparound past 0xFFFFFFFF is reached in two ticks rather than after billions of cycles. The full-width offset lets the bench probe unmapped words above 0x1C and unaligned offsets. With four channels the watchdog sits on the last compare register, so the bench can drive it with its interrupt enable off. That shows the watchdog runs separately from the event path.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  // word index of the fixed registers (byte offset / 4)
  localparam int IDX_CNT  = 4;
  localparam int IDX_STAT = 5;
  localparam int IDX_WDOG = 6;
  localparam int IDX_IEN  = 7;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_op_e;
endpackage

// File: rtl/cmpt_counter.sv
module cmpt_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] cnt_nxt,
  output logic              upd
);
  assign upd     = tick | load;
  assign cnt_nxt = load ? load_val : cnt + DATA_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (upd) cnt <= cnt_nxt;
  end

  a_r6_tick_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> (cnt == $past(cnt) + DATA_W'(1)));
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/cmpt_channel.sv
module cmpt_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmp,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd,
  input  logic [DATA_W-1:0] cnt_nxt,
  input  logic              ien,
  input  logic              clr,
  output logic [DATA_W-1:0] cmp_val,
  output logic              hit,
  output logic              status
);
  assign hit = upd && (cnt_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_val <= '0;
      status  <= 1'b0;
    end else begin
      if (wr_cmp) cmp_val <= wdata;
      status <= (status & ~clr) | (hit & ien);
    end
  end

  a_r3_disabled_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !status) |=> !status);
  a_r4_clear_drops_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !status);
  a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ien) |=> status);
endmodule

// File: rtl/cmpt_regs.sv
module cmpt_regs
  import cmpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int IEN_W  = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic                          rsp_valid,
  output logic [DATA_W-1:0]             rsp_rdata,
  output logic                          rsp_err,
  input  logic [DATA_W-1:0]             cnt,
  input  logic [NUM_CH-1:0][DATA_W-1:0] cmp_vals,
  input  logic [NUM_CH-1:0]             status,
  input  logic                          wd_hit,
  output logic                          load,
  output logic [NUM_CH-1:0]             cmp_wr,
  output logic [NUM_CH-1:0]             stat_clr,
  output logic [NUM_CH-1:0]             ch_en,
  output logic                          wdog_rst_req
);
  localparam int IDX_W = ADDR_W - 2;

  bus_op_e           op;
  logic              aligned;
  logic [IDX_W-1:0]  idx;
  logic              wr_ok;
  logic [IEN_W-1:0]  ien_q;
  logic              wd_q;
  logic              wd_trig;
  logic [DATA_W-1:0] rvalue;
  logic              rerr;

  assign req_ready = 1'b1;
  assign op = !(req_valid && req_ready) ? BUS_IDLE : (req_write ? BUS_WRITE : BUS_READ);
  assign aligned = (req_addr[1:0] == 2'b00);
  assign idx     = req_addr[ADDR_W-1:2];
  assign wr_ok   = (op == BUS_WRITE) && aligned;

  assign load     = wr_ok && (idx == IDX_W'(IDX_CNT));
  assign stat_clr = (wr_ok && (idx == IDX_W'(IDX_STAT))) ? req_wdata[NUM_CH-1:0] : '0;
  assign ch_en    = ien_q[NUM_CH-1:0];
  assign wd_trig  = wd_hit && wd_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wsel
    assign cmp_wr[i] = wr_ok && (idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q        <= '0;
      wd_q         <= 1'b0;
      wdog_rst_req <= 1'b0;
    end else begin
      if (wr_ok && (idx == IDX_W'(IDX_IEN))) ien_q <= req_wdata[IEN_W-1:0];
      wdog_rst_req <= wd_trig;
      if (wd_trig)                                 wd_q <= 1'b0;
      else if (wr_ok && (idx == IDX_W'(IDX_WDOG))) wd_q <= req_wdata[0];
    end
  end

  always_comb begin
    logic found;
    rvalue = '0;
    rerr   = 1'b0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (idx == IDX_W'(i)) begin
        rvalue = cmp_vals[i];
        found  = 1'b1;
      end
    end
    if (!found) begin
      if (idx == IDX_W'(IDX_CNT))       rvalue = cnt;
      else if (idx == IDX_W'(IDX_STAT)) rvalue = DATA_W'(status);
      else if (idx == IDX_W'(IDX_WDOG)) rvalue = DATA_W'(wd_q);
      else if (idx == IDX_W'(IDX_IEN))  rvalue = DATA_W'(ien_q);
      else                              rerr   = 1'b1;
    end
    if (!aligned) begin
      rvalue = '0;
      rerr   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= (op == BUS_READ);
      rsp_rdata <= (op == BUS_READ && !rerr) ? rvalue : '0;
      rsp_err   <= (op == BUS_READ) && rerr;
    end
  end

  a_r5_disarm_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |-> !wd_q);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |=> !wdog_rst_req);
  a_r9_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  a_r10_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_rdata == '0));
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int DATA_W = 32,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int IEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [NUM_CH-1:0] irq,
  output logic              wdog_rst_req
);
  localparam int WD_CH = NUM_CH - 1;

  logic [DATA_W-1:0]             cnt;
  logic [DATA_W-1:0]             cnt_nxt;
  logic                          upd;
  logic                          load;
  logic [NUM_CH-1:0][DATA_W-1:0] cmp_vals;
  logic [NUM_CH-1:0]             status;
  logic [NUM_CH-1:0]             hit;
  logic [NUM_CH-1:0]             cmp_wr;
  logic [NUM_CH-1:0]             stat_clr;
  logic [NUM_CH-1:0]             ch_en;

  cmpt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(load), .load_val(req_wdata),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .upd(upd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    cmpt_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr_cmp(cmp_wr[i]), .wdata(req_wdata),
      .upd(upd), .cnt_nxt(cnt_nxt), .ien(ch_en[i]), .clr(stat_clr[i]),
      .cmp_val(cmp_vals[i]), .hit(hit[i]), .status(status[i])
    );
  end

  cmpt_regs #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IEN_W(IEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .cnt(cnt), .cmp_vals(cmp_vals), .status(status), .wd_hit(hit[WD_CH]),
    .load(load), .cmp_wr(cmp_wr), .stat_clr(stat_clr), .ch_en(ch_en),
    .wdog_rst_req(wdog_rst_req)
  );

  assign irq = status;

  a_r1_quiet_irq_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq & ~ch_en) <= $countones($past(irq) & ~ch_en)) || !$stable(ch_en));
endmodule

// File: tb/cmp_timer_tb.sv
`timescale 1ns/100ps
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [3:0]  irq;
  logic        wdog_rst_req;

  int vectors = 0;
  int miscompares = 0;

  // behavioural reference state
  logic [31:0] m_cmp [4];
  logic [31:0] m_cnt;
  logic [3:0]  m_st;
  logic [11:0] m_ien;
  logic        m_wd;
  logic        m_rv, m_rerr, m_rst;
  logic [31:0] m_rdata;

  always #2.5 clk = ~clk;

  cmp_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq(irq), .wdog_rst_req(wdog_rst_req)
  );

  task automatic model(input bit v, input bit w, input logic [7:0] a,
                       input logic [31:0] d, input bit t);
    logic [31:0] nc;
    logic [3:0]  ev, clr;
    bit upd, ld, rd;
    logic [31:0] rv;
    bit err;
    ld  = v && w && a == 8'h10;
    rd  = v && !w;
    upd = t || ld;
    nc  = ld ? d : m_cnt + 32'd1;
    ev  = '0;
    for (int i = 0; i < 4; i++) if (upd && nc == m_cmp[i]) ev[i] = 1'b1;
    clr = (v && w && a == 8'h14) ? d[3:0] : 4'h0;
    err = 0; rv = 0;
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: rv = m_cmp[a >> 2];
      8'h10: rv = m_cnt;
      8'h14: rv = {28'h0, m_st};
      8'h18: rv = {31'h0, m_wd};
      8'h1C: rv = {20'h0, m_ien};
      default: err = 1;
    endcase
    m_rv = rd; m_rerr = rd && err; m_rdata = (rd && !err) ? rv : 32'h0;
    m_rst = ev[3] && m_wd;
    m_st  = (m_st & ~clr) | (ev & m_ien[3:0]);
    if (m_rst) m_wd = 1'b0;
    else if (v && w && a == 8'h18) m_wd = d[0];
    if (v && w && a == 8'h1C) m_ien = d[11:0];
    if (v && w && a[1:0] == 2'b00 && a < 8'h10) m_cmp[a >> 2] = d;
    if (upd) m_cnt = nc;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compare(input string tag);
    vectors++;
    chk(tag, "rsp_valid", 32'(rsp_valid), 32'(m_rv));
    chk(tag, "rsp_rdata", rsp_rdata, m_rdata);
    chk(tag, "rsp_err", 32'(rsp_err), 32'(m_rerr));
    chk(tag, "irq", 32'(irq), 32'(m_st));
    chk(tag, "wdog_rst_req", 32'(wdog_rst_req), 32'(m_rst));
    chk({tag, "/R10"}, "req_ready", 32'(req_ready), 32'd1);
  endtask

  task automatic step(input string tag, input bit v, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input bit t);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d; tick_en = t;
    @(posedge clk);
    model(v, w, a, d, t);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d,
                    input bit t = 0);
    step(tag, 1, 1, a, d, t);
  endtask
  task automatic rd(input string tag, input logic [7:0] a, input bit t = 0);
    step(tag, 1, 0, a, 32'h0, t);
  endtask
  task automatic idle(input string tag, input bit t);
    step(tag, 0, 0, 8'h0, 32'h0, t);
  endtask
  task automatic read_all(input string tag);
    for (int i = 0; i < 8; i++) rd(tag, 8'(i * 4));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    m_cnt = 0; m_st = 0; m_ien = 0; m_wd = 0;
    m_rv = 0; m_rerr = 0; m_rst = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    read_all("R1 reset registers");

    // R2: map and readback, enable masked to 12 bits
    for (int i = 0; i < 4; i++) wr("R2 cmp write", 8'(i * 4), 32'hA5A5_0000 + 32'(i));
    wr("R2 ien write", 8'h1C, 32'hFFFF_FFFF);
    wr("R2 cnt write", 8'h10, 32'h0000_0100);
    wr("R2 wdog write", 8'h18, 32'hFFFF_FFFE);
    read_all("R2 readback");
    wr("R2 ien clear", 8'h1C, 32'h0);
    rd("R2 read sees pre-write", 8'h10);

    // R3: enabled channel fires, disabled one does not
    wr("R3 cnt", 8'h10, 32'h0);
    wr("R3 cmp0", 8'h00, 32'd5);
    wr("R3 cmp1", 8'h04, 32'd3);
    wr("R3 ien", 8'h1C, 32'h1);
    for (int i = 0; i < 6; i++) idle("R3 ticking", 1);
    rd("R3 status", 8'h14);

    // R4: write-one-to-clear
    wr("R4 clear zero bits", 8'h14, 32'h2);
    rd("R4 status kept", 8'h14);
    wr("R4 clear bit0", 8'h14, 32'h1);
    rd("R4 status cleared", 8'h14);
    wr("R4 arm cmp0", 8'h00, 32'd20);
    wr("R4 load onto cmp0", 8'h10, 32'd20);
    wr("R4 cmp0 next", 8'h00, 32'd21);
    wr("R4 clear with event", 8'h14, 32'h1, 1);
    rd("R4 event wins", 8'h14);

    // R7: holding count gives no repeat event
    wr("R7 clear", 8'h14, 32'hF);
    for (int i = 0; i < 8; i++) idle("R7 hold", 0);
    rd("R7 count held", 8'h10);
    rd("R7 no refire", 8'h14);

    // R6: wraparound
    wr("R6 ien", 8'h1C, 32'h4);
    wr("R6 cmp2 zero", 8'h08, 32'h0);
    wr("R6 load top", 8'h10, 32'hFFFF_FFFE);
    idle("R6 tick to max", 1);
    idle("R6 tick wraps", 1);
    rd("R6 count zero", 8'h10);

    // R8: counter load counts as transition, beats tick
    wr("R8 ien", 8'h1C, 32'h2);
    wr("R8 cmp1", 8'h04, 32'h1234);
    wr("R8 load match", 8'h10, 32'h1234);
    wr("R8 load with tick", 8'h10, 32'h40, 1);
    rd("R8 count loaded", 8'h10);
    wr("R8 clear", 8'h14, 32'hF);

    // R5: watchdog, independent of enable bit 3
    wr("R5 ien off", 8'h1C, 32'h0);
    wr("R5 cnt", 8'h10, 32'd100);
    wr("R5 cmp3", 8'h0C, 32'd102);
    wr("R5 arm", 8'h18, 32'h1);
    idle("R5 tick", 1);
    idle("R5 trigger", 1);
    idle("R5 pulse ends", 0);
    rd("R5 disarmed", 8'h18);
    wr("R5 cmp3 next", 8'h0C, 32'd103);
    wr("R5 rearm", 8'h18, 32'h1);
    wr("R5 write during trigger", 8'h18, 32'h1, 1);
    rd("R5 trigger wins", 8'h18);
    rd("R5 no status bit", 8'h14);

    // R9: bad offsets
    rd("R9 unmapped 0x20", 8'h20);
    rd("R9 unaligned 0x02", 8'h02);
    rd("R9 unmapped 0xFC", 8'hFC);
    wr("R9 write unmapped", 8'h24, 32'hDEAD_BEEF);
    wr("R9 write unaligned", 8'h11, 32'hDEAD_BEEF);
    read_all("R9 nothing changed");
    idle("R10 idle", 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule